// File: doc/BRIEF.md
# Keyed System Control Register Block

This block is the control and status register file of a processor core module. A host reaches it through a small request/response register bus. Each request carries a byte offset inside a 512-byte window, a write flag and 32 bits of write data. The file holds the following:

- constant identification and status words
- two oscillator settings that can only be changed after a 16-bit key has been written
- a control word that drives an LED, selects the boot-memory remap and can request a system reset
- SDRAM and init settings
- two flag words, each with its own set address and clear address
- a free-running count of a 24 MHz reference, derived from the bus clock by a prescaler
- a read-only byte window that returns memory-module presence-detect data

The bus is a valid/ready stream. A request is accepted on a rising edge where `req_valid_i` and `req_ready_o` are both high. Every accepted request, read or write, gives exactly one response beat one cycle later. A write's response carries zero. The response stays on `rsp_valid_o`/`rsp_rdata_o` until `rsp_ready_i` is high. While a response is waiting and `rsp_ready_i` is low, `req_ready_o` is low, so back-pressure passes straight through to the requester. With `rsp_ready_i` held high the block takes one request every cycle.

The memory-size input is treated as static. It is sampled during reset, and the sampled value sets the reset value of the SDRAM word and one byte of the presence-detect table.

Top module: `keyed_sysctl`

## Requirements
- R1: Word index is the byte offset divided by 4. Index 0 reads 0x411A3001, index 1 reads 0, and index 4 reads 0x00100000.
- R2: A write to index 5 keeps data bits [15:0] as the key. A read returns 0x0001A05F while the kept key is 0xA05F, and otherwise returns the kept key zero-extended. The key resets to 0.
- R3: Index 2 (reset 0x01000048) and index 7 (reset 0x0007FEFF) take write data only while the kept key is 0xA05F. At any other time a write leaves them unchanged.
- R4: A write to index 3 keeps bits 0 and 2 only, and index 3 reads back {bit2, 0, bit0}. `led_o` follows bit 0. `remap_o` follows bit 2: 0 maps boot flash at address 0, 1 maps RAM there. Both reset to 0.
- R5: A write to index 3 with data bit 3 set raises `sys_reset_req_o` for exactly one cycle, starting at the accepting edge. Bit 3 always reads 0.
- R6: A write to index 12 ORs the data into the flag word. A write to index 13 clears the bits written as 1. Index 12 reads the flag word and index 13 reads 0. The flag word resets to 0.
- R7: Indexes 14 and 15 behave in the same way for the nonvolatile flag word, which is read at index 14 and resets to 0.
- R8: Index 9 resets to 0x00000112. Index 8 resets to 0x00011122 ORed with a size code from `mem_mb_i`: 0x10 for 256 or more, 0x0C for 128 to 255, 0x08 for 64 to 127, 0x04 for 32 to 63, and 0 below 32. Both take any written value.
- R9: Index 10 reads a 32-bit counter. It resets to 0 and advances by one every REFDIV bus clocks.
- R10: Byte offsets 0x100 to 0x17F return in bits [7:0] the table entry whose number is offset minus 0x100, with the upper bits 0. Entries 0 to 30 are 80 08 04 0B 09 01 40 00 02 A0 A0 00 00 08 00 01 0E 04 1C 01 02 20 C0 00 00 00 00 30 28 30 28 (hex). Entry 31 is 0x40, 0x20, 0x10, 0x04 or 0x02 for the same size bands as R8. Entries 32 to 127 are 0, and offsets 0x180 to 0x1FF read 0.
- R11: Reads of any other index return 0. Writes to indexes 0, 1, 4, 6, 10, 11 and 16 to 63, and to the byte window, change nothing.
- R12: Every accepted request gives one response, one cycle later. While `rsp_ready_i` is low, the response holds its data and `req_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_mb_i | input | 16 | Fitted memory size in MB, sampled during reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | 9 | Byte offset |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Requester takes the response |
| rsp_rdata_o | output | 32 | Read data (0 for writes) |
| remap_o | output | 1 | 0: boot flash at address 0, 1: RAM at address 0 |
| led_o | output | 1 | LED drive |
| sys_reset_req_o | output | 1 | One-cycle system reset request |

## Verification
Register state is visible only through reads, and a read shows it one cycle after acceptance.

- A wrong key compare or a wrong gate shows on the next read of an oscillator word: a locked write would have landed, or an unlocked write would be missing.
- A wrong set/clear mask or an error in the remap or LED storage shows on the next readback of that word. The LED and remap pins show it in the cycle after the write.
- A wrong reset-request pulse shows on the pin within one cycle.
- A wrong prescaler count shows as a wrong difference between two counter reads taken a known number of cycles apart.
- A misindexed table entry or register decode shows on the first sweep that visits that offset.

// File: rtl/ksc_pkg.sv
package ksc_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 9;
  localparam int IDX_W    = ADDR_W - 2;
  localparam int TBL_W    = 7;

  localparam int IX_ID      = 0;
  localparam int IX_PROC    = 1;
  localparam int IX_OSC     = 2;
  localparam int IX_CTRL    = 3;
  localparam int IX_STAT    = 4;
  localparam int IX_LOCK    = 5;
  localparam int IX_AUX     = 7;
  localparam int IX_SDRAM   = 8;
  localparam int IX_INIT    = 9;
  localparam int IX_COUNT   = 10;
  localparam int IX_FLG_SET = 12;
  localparam int IX_FLG_CLR = 13;
  localparam int IX_NVF_SET = 14;
  localparam int IX_NVF_CLR = 15;

  localparam logic [DATA_W-1:0] ID_WORD   = 32'h411A_3001;
  localparam logic [DATA_W-1:0] STAT_WORD = 32'h0010_0000;
  localparam logic [DATA_W-1:0] OSC_RST   = 32'h0100_0048;
  localparam logic [DATA_W-1:0] AUX_RST   = 32'h0007_FEFF;
  localparam logic [DATA_W-1:0] SDRAM_RST = 32'h0001_1122;
  localparam logic [DATA_W-1:0] INIT_RST  = 32'h0000_0112;
  localparam logic [15:0]       LOCK_KEY  = 16'hA05F;

  typedef enum logic [2:0] {
    SZ_SMALL = 3'd0,
    SZ_32    = 3'd1,
    SZ_64    = 3'd2,
    SZ_128   = 3'd3,
    SZ_256   = 3'd4
  } size_cls_e;

  function automatic size_cls_e classify_size(input logic [15:0] mb);
    if (mb >= 16'd256)      return SZ_256;
    else if (mb >= 16'd128) return SZ_128;
    else if (mb >= 16'd64)  return SZ_64;
    else if (mb >= 16'd32)  return SZ_32;
    else                    return SZ_SMALL;
  endfunction

  function automatic logic [7:0] sdram_size_bits(input size_cls_e c);
    case (c)
      SZ_256:  return 8'h10;
      SZ_128:  return 8'h0C;
      SZ_64:   return 8'h08;
      SZ_32:   return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] pd_size_byte(input size_cls_e c);
    case (c)
      SZ_256:  return 8'h40;
      SZ_128:  return 8'h20;
      SZ_64:   return 8'h10;
      SZ_32:   return 8'h04;
      default: return 8'h02;
    endcase
  endfunction

endpackage

// File: rtl/ksc_refcnt.sv
module ksc_refcnt #(
  parameter int DIV   = 4,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count_o
);

  logic tick;

  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst)              pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                  pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       count_o <= '0;
    else if (tick) count_o <= count_o + 1'b1;
  end

endmodule

// File: rtl/ksc_pdrom.sv
module ksc_pdrom
  import ksc_pkg::*;
(
  input  logic [TBL_W-1:0] idx_i,
  input  size_cls_e        size_i,
  output logic [7:0]       byte_o
);

  always_comb begin
    case (idx_i)
      7'd0:  byte_o = 8'h80;
      7'd1:  byte_o = 8'h08;
      7'd2:  byte_o = 8'h04;
      7'd3:  byte_o = 8'h0B;
      7'd4:  byte_o = 8'h09;
      7'd5:  byte_o = 8'h01;
      7'd6:  byte_o = 8'h40;
      7'd8:  byte_o = 8'h02;
      7'd9:  byte_o = 8'hA0;
      7'd10: byte_o = 8'hA0;
      7'd13: byte_o = 8'h08;
      7'd15: byte_o = 8'h01;
      7'd16: byte_o = 8'h0E;
      7'd17: byte_o = 8'h04;
      7'd18: byte_o = 8'h1C;
      7'd19: byte_o = 8'h01;
      7'd20: byte_o = 8'h02;
      7'd21: byte_o = 8'h20;
      7'd22: byte_o = 8'hC0;
      7'd27: byte_o = 8'h30;
      7'd28: byte_o = 8'h28;
      7'd29: byte_o = 8'h30;
      7'd30: byte_o = 8'h28;
      7'd31: byte_o = pd_size_byte(size_i);
      default: byte_o = 8'h00;
    endcase
  end

endmodule

// File: rtl/ksc_regfile.sv
module ksc_regfile
  import ksc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       mem_mb_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [DATA_W-1:0] count_i,
  output logic              led_o,
  output logic              remap_o,
  output logic              rst_req_o
);

  logic [DATA_W-1:0] osc_q, aux_q, sdram_q, init_q, flags_q, nvflags_q;
  logic [15:0]       key_q;
  logic              unlocked;

  assign unlocked = (key_q == LOCK_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_q     <= OSC_RST;
      aux_q     <= AUX_RST;
      sdram_q   <= SDRAM_RST | {24'b0, sdram_size_bits(classify_size(mem_mb_i))};
      init_q    <= INIT_RST;
      flags_q   <= '0;
      nvflags_q <= '0;
      key_q     <= '0;
      led_o     <= 1'b0;
      remap_o   <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= 1'b0;
      if (wr_en_i) begin
        case (wr_idx_i)
          IDX_W'(IX_OSC):     if (unlocked) osc_q <= wr_data_i;
          IDX_W'(IX_AUX):     if (unlocked) aux_q <= wr_data_i;
          IDX_W'(IX_CTRL): begin
            led_o     <= wr_data_i[0];
            remap_o   <= wr_data_i[2];
            rst_req_o <= wr_data_i[3];
          end
          IDX_W'(IX_LOCK):    key_q     <= wr_data_i[15:0];
          IDX_W'(IX_SDRAM):   sdram_q   <= wr_data_i;
          IDX_W'(IX_INIT):    init_q    <= wr_data_i;
          IDX_W'(IX_FLG_SET): flags_q   <= flags_q | wr_data_i;
          IDX_W'(IX_FLG_CLR): flags_q   <= flags_q & ~wr_data_i;
          IDX_W'(IX_NVF_SET): nvflags_q <= nvflags_q | wr_data_i;
          IDX_W'(IX_NVF_CLR): nvflags_q <= nvflags_q & ~wr_data_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_idx_i)
      IDX_W'(IX_ID):      rd_data_o = ID_WORD;
      IDX_W'(IX_OSC):     rd_data_o = osc_q;
      IDX_W'(IX_CTRL):    rd_data_o = {29'b0, remap_o, 1'b0, led_o};
      IDX_W'(IX_STAT):    rd_data_o = STAT_WORD;
      IDX_W'(IX_LOCK):    rd_data_o = {15'b0, unlocked, key_q};
      IDX_W'(IX_AUX):     rd_data_o = aux_q;
      IDX_W'(IX_SDRAM):   rd_data_o = sdram_q;
      IDX_W'(IX_INIT):    rd_data_o = init_q;
      IDX_W'(IX_COUNT):   rd_data_o = count_i;
      IDX_W'(IX_FLG_SET): rd_data_o = flags_q;
      IDX_W'(IX_NVF_SET): rd_data_o = nvflags_q;
      default:            rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/keyed_sysctl.sv
module keyed_sysctl
  import ksc_pkg::*;
#(
  parameter int REFDIV = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        mem_mb_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic               remap_o,
  output logic               led_o,
  output logic               sys_reset_req_o
);

  localparam int WIN_BIT  = ADDR_W - 1;
  localparam int HALF_BIT = TBL_W;

  logic              accept, in_window;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] reg_rd, word_rd, ref_cnt;
  logic [7:0]        pd_byte;
  size_cls_e         size_q;

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;
  assign in_window   = req_addr_i[WIN_BIT];
  assign idx         = req_addr_i[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) size_q <= classify_size(mem_mb_i);
  end

  ksc_refcnt #(.DIV(REFDIV), .CNT_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .count_o (ref_cnt)
  );

  ksc_pdrom u_pd (
    .idx_i  (req_addr_i[TBL_W-1:0]),
    .size_i (size_q),
    .byte_o (pd_byte)
  );

  ksc_regfile u_regs (
    .clk       (clk),
    .rst       (rst),
    .mem_mb_i  (mem_mb_i),
    .wr_en_i   (accept && req_write_i && !in_window),
    .wr_idx_i  (idx),
    .wr_data_i (req_wdata_i),
    .rd_idx_i  (idx),
    .rd_data_o (reg_rd),
    .count_i   (ref_cnt),
    .led_o     (led_o),
    .remap_o   (remap_o),
    .rst_req_o (sys_reset_req_o)
  );

  always_comb begin
    if (!in_window)                word_rd = reg_rd;
    else if (req_addr_i[HALF_BIT]) word_rd = '0;
    else                           word_rd = {24'b0, pd_byte};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else if (accept) begin
      rsp_valid_o <= 1'b1;
      rsp_rdata_o <= req_write_i ? '0 : word_rd;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/ksc_checker.sv
module ksc_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        led,
  input logic        remap,
  input logic        rst_req,
  input logic [31:0] refcnt
);

  assert_rst_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  assert_rst_cause_R5: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(req_valid && req_ready && req_write));

  assert_pins_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready && req_write) |=> ($stable(led) && $stable(remap)));

  assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (rst)
    (refcnt == $past(refcnt)) || (refcnt == $past(refcnt) + 32'd1));

endmodule

bind keyed_sysctl ksc_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid_i),
  .req_ready (req_ready_o),
  .req_write (req_write_i),
  .rsp_valid (rsp_valid_o),
  .rsp_ready (rsp_ready_i),
  .rsp_rdata (rsp_rdata_o),
  .led       (led_o),
  .remap     (remap_o),
  .rst_req   (sys_reset_req_o),
  .refcnt    (ref_cnt)
);

// File: tb/sim_keyed_sysctl.sv
module sim_keyed_sysctl;

  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_mb = 16'd300;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [8:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, remap, led, rst_req;
  logic [31:0] rsp_rdata;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_sysctl #(.REFDIV(DIV)) u0 (
    .clk(clk), .rst(rst), .mem_mb_i(mem_mb),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .remap_o(remap), .led_o(led), .sys_reset_req_o(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [8:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_rdata;
    if (rsp_valid !== 1'b1) chk("R12 rsp_valid", {31'b0, rsp_valid}, 32'd1);
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    logic [31:0] r;
    bus(1'b1, 9'(idx * 4), d, r);
  endtask

  task automatic rd(input int idx, output logic [31:0] r);
    bus(1'b0, 9'(idx * 4), 32'h0, r);
  endtask

  function automatic logic [7:0] size_bits(input int mb);
    if (mb >= 256) return 8'h10;
    if (mb >= 128) return 8'h0C;
    if (mb >= 64)  return 8'h08;
    if (mb >= 32)  return 8'h04;
    return 8'h00;
  endfunction

  function automatic logic [7:0] size_byte(input int mb);
    if (mb >= 256) return 8'h40;
    if (mb >= 128) return 8'h20;
    if (mb >= 64)  return 8'h10;
    if (mb >= 32)  return 8'h04;
    return 8'h02;
  endfunction

  function automatic logic [31:0] exp_reset(input int idx, input int mb);
    case (idx)
      0: return 32'h411A3001;
      2: return 32'h01000048;
      4: return 32'h00100000;
      7: return 32'h0007FEFF;
      8: return 32'h00011122 | {24'b0, size_bits(mb)};
      9: return 32'h00000112;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_window(input int off, input int mb);
    logic [7:0] t [0:30];
    t = '{8'h80, 8'h08, 8'h04, 8'h0B, 8'h09, 8'h01, 8'h40, 8'h00, 8'h02, 8'hA0, 8'hA0,
          8'h00, 8'h00, 8'h08, 8'h00, 8'h01, 8'h0E, 8'h04, 8'h1C, 8'h01, 8'h02, 8'h20,
          8'hC0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h30, 8'h28, 8'h30, 8'h28};
    if (off >= 'h180) return 32'h0;
    if (off - 'h100 < 31) return {24'b0, t[off - 'h100]};
    if (off - 'h100 == 31) return {24'b0, size_byte(mb)};
    return 32'h0;
  endfunction

  task automatic do_reset(input int mb);
    @(negedge clk);
    mem_mb = 16'(mb);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic bit no_effect_idx(input int i);
    return (i == 0 || i == 1 || i == 4 || i == 6 || i == 10 || i == 11 || i >= 16);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r, a, b;
    int sizes [5] = '{300, 128, 100, 40, 16};

    // Reset state at the pins
    repeat (2) @(negedge clk);
    chk("R4 led reset", {31'b0, led}, 32'd0);
    chk("R4 remap reset", {31'b0, remap}, 32'd0);
    chk("R5 reset req idle", {31'b0, rst_req}, 32'd0);
    chk("R12 rsp idle", {31'b0, rsp_valid}, 32'd0);

    foreach (sizes[k]) begin
      do_reset(sizes[k]);
      rd(10, r);
      chk("R9 counter near zero after reset", {31'b0, (r < 32'd2)}, 32'd1);
      // R1 R8 R11: register sweep of reset values
      for (int i = 0; i < 64; i++) begin
        if (i == 10) continue;
        rd(i, r);
        chk($sformatf("R1/R8/R11 reset idx %0d mb %0d", i, sizes[k]), r, exp_reset(i, sizes[k]));
      end
      // R10: byte window sweep
      for (int off = 'h100; off < 'h200; off++) begin
        bus(1'b0, 9'(off), 32'h0, r);
        chk($sformatf("R10 window %h mb %0d", off, sizes[k]), r, exp_window(off, sizes[k]));
      end
    end

    // R11: writes with no effect, including into the window
    for (int i = 0; i < 64; i++)
      if (no_effect_idx(i)) wr(i, 32'hFFFF_FFFF);
    for (int off = 'h100; off < 'h200; off += 4) bus(1'b1, 9'(off), 32'hFFFF_FFFF, r);
    for (int i = 0; i < 64; i++) begin
      if (i == 10) continue;
      rd(i, r);
      chk($sformatf("R11 unchanged idx %0d", i), r, exp_reset(i, 16));
    end
    bus(1'b0, 9'h11F, 32'h0, r);
    chk("R11 window unchanged", r, 32'h02);
    chk("R11 led untouched", {31'b0, led}, 32'd0);

    // R2 / R3 key-guarded oscillator words
    wr(2, 32'h1234_5678); rd(2, r); chk("R3 osc locked", r, 32'h01000048);
    wr(7, 32'h1111_2222); rd(7, r); chk("R3 aux locked", r, 32'h0007FEFF);
    wr(5, 32'hFFFF_A05F); rd(5, r); chk("R2 key readback", r, 32'h0001A05F);
    wr(2, 32'h1234_5678); rd(2, r); chk("R3 osc unlocked", r, 32'h12345678);
    wr(7, 32'h1111_2222); rd(7, r); chk("R3 aux unlocked", r, 32'h11112222);
    wr(5, 32'h0000_A05E); rd(5, r); chk("R2 near key", r, 32'h0000A05E);
    wr(2, 32'hDEAD_BEEF); rd(2, r); chk("R3 osc relocked", r, 32'h12345678);
    wr(5, 32'h0001_0000); rd(5, r); chk("R2 upper bits dropped", r, 32'h0);

    // R4 / R5 control word
    wr(3, 32'hFFFF_FFF7); rd(3, r); chk("R4 ctrl mask", r, 32'h5);
    chk("R4 led on", {31'b0, led}, 32'd1);
    chk("R4 remap ram", {31'b0, remap}, 32'd1);
    wr(3, 32'h0000_0004);
    chk("R4 led off", {31'b0, led}, 32'd0);
    chk("R4 remap held", {31'b0, remap}, 32'd1);
    chk("R5 no pulse", {31'b0, rst_req}, 32'd0);
    wr(3, 32'h0000_0008);
    chk("R5 pulse high", {31'b0, rst_req}, 32'd1);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'b0, rst_req}, 32'd0);
    rd(3, r); chk("R5 bit3 reads 0", r, 32'h0);
    chk("R4 remap flash", {31'b0, remap}, 32'd0);

    // R6 / R7 set and clear pairs
    wr(12, 32'h0000_F0F0); wr(12, 32'h0000_000F);
    rd(12, r); chk("R6 flag set", r, 32'h0000F0FF);
    wr(13, 32'h0000_00F1); rd(12, r); chk("R6 flag clear", r, 32'h0000F00E);
    rd(13, r); chk("R6 clear addr reads 0", r, 32'h0);
    rd(14, r); chk("R7 nv untouched", r, 32'h0);
    wr(14, 32'h8000_0003); wr(15, 32'h0000_0001);
    rd(14, r); chk("R7 nv set/clear", r, 32'h80000002);
    rd(15, r); chk("R7 clear addr reads 0", r, 32'h0);
    rd(12, r); chk("R6 untouched by nv", r, 32'h0000F00E);

    // R8 SDRAM/init writable
    wr(8, 32'hA5A5_0001); rd(8, r); chk("R8 sdram write", r, 32'hA5A50001);
    wr(9, 32'h0000_0000); rd(9, r); chk("R8 init write", r, 32'h0);

    // R9 rate: accepts 40 cycles apart -> 40/DIV ticks
    rd(10, a);
    repeat (38) @(negedge clk);
    rd(10, b);
    chk("R9 counter rate", b - a, 32'(40 / DIV));

    // R12 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 9'h000;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 rsp valid", {31'b0, rsp_valid}, 32'd1);
    chk("R12 rsp data", rsp_rdata, 32'h411A3001);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R12 rsp held", rsp_rdata, 32'h411A3001);
      chk("R12 ready low", {31'b0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R12 rsp drained", {31'b0, rsp_valid}, 32'd0);
    chk("R12 ready high", {31'b0, req_ready}, 32'd1);

    finish_run();
  end

endmodule